// File: doc/BRIEF.md
# Dual-Port RAM with Collision Busy Arbitration

This block is a clocked model of a true dual-port memory. A left port and a right port each have their own chip enable, read/write select, output enable, semaphore select, address and data. Either port can read or write any word at any time, and both ports can address the same word at once. A single clock stands in for asynchronous timing. Read data is registered, and it is presented as a data bus plus an output-enable flag in place of tri-state drivers.

When both ports select the same word, an arbiter picks a winner and pulls the loser's active-low busy output low. The port whose access started first wins. If both start in the same cycle, the left port wins. The loser's writes are dropped and its reads go ahead.

A master/slave strap selects where busy comes from. In master mode the arbiter drives the busy outputs. In slave mode the busy outputs are held high, and an active-low busy input from a cascaded master blocks each port's writes. Several devices can be placed side by side this way to build a wider word.

Top module: `dual_port_busy_ram`

## Requirements
- R1: The storage holds 2^ADDR_W words of DATA_W bits. The defaults are ADDR_W=10 and DATA_W=8; ADDR_W=15 gives the full 32K x 8 array. A port with ce_n=0, rw_n=0 and sem_n=1 stores its wdata at the addressed word on the clock edge, and either port can write any word.
- R2: A port with ce_n=0, rw_n=1, oe_n=0 and sem_n=1 raises rd_oe in the next cycle, with rdata equal to the addressed word.
- R3: oe_n=1 gives rd_oe=0 in the next cycle. ce_n=1 or sem_n=0 causes no memory access at all: no write, and rd_oe=0 in the next cycle.
- R4: During reset and after reset, with both ports idle, rd_oe is 0 on both ports, busy_n is 1 on both ports, and no arbitration history remains.
- R5: In master mode a busy output goes low only while both ports are accessing (ce_n=0, sem_n=1) the same address. Otherwise both busy outputs stay high.
- R6: A port arrives in the cycle it begins an access or changes its address. On a collision the port that arrived earlier wins, and the other port's busy_n is 0.
- R7: When both ports arrive at the same address in the same cycle, the left port wins and r_busy_n is 0.
- R8: The loser's busy_n stays 0 for every cycle that both ports hold the same address. It returns to 1 in the same cycle the collision ends.
- R9: In master mode a write from a port whose busy_n is 0 does not change memory. A read from such a port still returns data.
- R10: In slave mode (mstr_sel=0) both busy outputs are driven high. A port whose busy_in_n is 0 has its write suppressed, and its reads are unaffected.
- R11: When one port writes a word and the other port reads the same word in the same cycle, the read returns the contents held before the write.
- R12: In slave mode, if both ports write the same word in the same cycle with neither blocked, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mstr_sel | input | 1 | 1 selects master (busy from arbiter), 0 selects slave |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw_n | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore select; 0 removes the port from memory access |
| l_addr | input | ADDR_W | Left address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data |
| l_rd_oe | output | 1 | Left read data valid/driven |
| l_busy_n | output | 1 | Left busy flag, active low |
| l_busy_in_n | input | 1 | Left busy input from master (slave mode), active low |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw_n | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore select |
| r_addr | input | ADDR_W | Right address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data |
| r_rd_oe | output | 1 | Right read data valid/driven |
| r_busy_n | output | 1 | Right busy flag, active low |
| r_busy_in_n | input | 1 | Right busy input from master (slave mode), active low |

## Verification
The assertions assume that each port's control and address inputs change only between clock edges and stay steady for a whole cycle. They also assume that mstr_sel does not toggle in the middle of a collision, because the busy hold property compares successive cycles. The stimulus changes inputs on the falling edge only and switches the strap only after both ports have gone idle. It also places an idle cycle between scenarios, so that each collision starts from a known arrival history.

// File: rtl/dpbr_pkg.sv
package dpbr_pkg;

  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,
    PM_WRITE = 2'd1,
    PM_READ  = 2'd2,
    PM_HIZ   = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;

  function automatic pmode_e decode_mode(input logic ce_n, input logic rw_n,
                                         input logic oe_n, input logic sem_n);
    if (ce_n || !sem_n) return PM_IDLE;
    else if (!rw_n)     return PM_WRITE;
    else if (!oe_n)     return PM_READ;
    else                return PM_HIZ;
  endfunction

endpackage

// File: rtl/dpbr_port_ctrl.sv
module dpbr_port_ctrl
  import dpbr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          rw_n,
  input  logic          oe_n,
  input  logic          sem_n,
  input  logic [AW-1:0] addr,
  output pmode_e        mode,
  output logic          acc,
  output logic          fresh
);

  logic          prev_acc_q, prev_acc_d;
  logic [AW-1:0] prev_addr_q, prev_addr_d;

  always_comb begin
    mode        = decode_mode(ce_n, rw_n, oe_n, sem_n);
    acc         = !ce_n && sem_n;
    fresh       = acc && !(prev_acc_q && (prev_addr_q == addr));
    prev_acc_d  = acc;
    prev_addr_d = acc ? addr : prev_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_acc_q  <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_acc_q  <= prev_acc_d;
      prev_addr_q <= prev_addr_d;
    end
  end

endmodule

// File: rtl/dpbr_arbiter.sv
module dpbr_arbiter
  import dpbr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_l,
  input  logic          acc_r,
  input  logic [AW-1:0] addr_l,
  input  logic [AW-1:0] addr_r,
  input  logic          fresh_l,
  input  logic          fresh_r,
  output logic          lose_l,
  output logic          lose_r
);

  logic clash, clash_q;
  win_e win_d, win_q;

  always_comb begin
    clash = acc_l && acc_r && (addr_l == addr_r);
    if (!clash)
      win_d = WIN_NONE;
    else if (clash_q && !fresh_l && !fresh_r)
      win_d = win_q;
    else if (fresh_r)
      win_d = WIN_LEFT;
    else if (fresh_l)
      win_d = WIN_RIGHT;
    else
      win_d = WIN_LEFT;
    lose_l = clash && (win_d == WIN_RIGHT);
    lose_r = clash && (win_d == WIN_LEFT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clash_q <= 1'b0;
      win_q   <= WIN_NONE;
    end else begin
      clash_q <= clash;
      win_q   <= win_d;
    end
  end

endmodule

// File: rtl/dpbr_store.sv
module dpbr_store #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_l,
  input  logic [AW-1:0] addr_l,
  input  logic [DW-1:0] wd_l,
  input  logic          we_r,
  input  logic [AW-1:0] addr_r,
  input  logic [DW-1:0] wd_r,
  output logic [DW-1:0] rd_l,
  output logic [DW-1:0] rd_r
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    rd_l = mem[addr_l];
    rd_r = mem[addr_r];
  end

  // left write is applied last so it prevails on a same-word double write
  always_ff @(posedge clk) begin
    if (we_r) mem[addr_r] <= wd_r;
    if (we_l) mem[addr_l] <= wd_l;
  end

endmodule

// File: rtl/dual_port_busy_ram.sv
module dual_port_busy_ram
  import dpbr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mstr_sel,
  input  logic              l_ce_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic              l_sem_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rd_oe,
  output logic              l_busy_n,
  input  logic              l_busy_in_n,
  input  logic              r_ce_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic              r_sem_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rd_oe,
  output logic              r_busy_n,
  input  logic              r_busy_in_n
);

  logic rst_q1, rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_s_n <= rst_q1;
    end
  end

  pmode_e mode_l, mode_r;
  logic   acc_l, acc_r, fresh_l, fresh_r, lose_l, lose_r;

  dpbr_port_ctrl #(.AW(ADDR_W)) u_pc_l (
    .clk(clk), .rst_n(rst_s_n), .ce_n(l_ce_n), .rw_n(l_rw_n), .oe_n(l_oe_n),
    .sem_n(l_sem_n), .addr(l_addr), .mode(mode_l), .acc(acc_l), .fresh(fresh_l)
  );

  dpbr_port_ctrl #(.AW(ADDR_W)) u_pc_r (
    .clk(clk), .rst_n(rst_s_n), .ce_n(r_ce_n), .rw_n(r_rw_n), .oe_n(r_oe_n),
    .sem_n(r_sem_n), .addr(r_addr), .mode(mode_r), .acc(acc_r), .fresh(fresh_r)
  );

  dpbr_arbiter #(.AW(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_s_n), .acc_l(acc_l), .acc_r(acc_r),
    .addr_l(l_addr), .addr_r(r_addr), .fresh_l(fresh_l), .fresh_r(fresh_r),
    .lose_l(lose_l), .lose_r(lose_r)
  );

  logic              blk_l, blk_r, we_l, we_r;
  logic [DATA_W-1:0] rd_l, rd_r;

  always_comb begin
    blk_l    = mstr_sel ? lose_l : !l_busy_in_n;
    blk_r    = mstr_sel ? lose_r : !r_busy_in_n;
    we_l     = (mode_l == PM_WRITE) && !blk_l;
    we_r     = (mode_r == PM_WRITE) && !blk_r;
    l_busy_n = mstr_sel ? !lose_l : 1'b1;
    r_busy_n = mstr_sel ? !lose_r : 1'b1;
  end

  dpbr_store #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .we_l(we_l), .addr_l(l_addr), .wd_l(l_wdata),
    .we_r(we_r), .addr_r(r_addr), .wd_r(r_wdata), .rd_l(rd_l), .rd_r(rd_r)
  );

  logic              oe_l_q, oe_l_d, oe_r_q, oe_r_d;
  logic [DATA_W-1:0] dat_l_q, dat_l_d, dat_r_q, dat_r_d;

  always_comb begin
    oe_l_d  = (mode_l == PM_READ);
    oe_r_d  = (mode_r == PM_READ);
    dat_l_d = oe_l_d ? rd_l : dat_l_q;
    dat_r_d = oe_r_d ? rd_r : dat_r_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      oe_l_q  <= 1'b0;
      oe_r_q  <= 1'b0;
      dat_l_q <= '0;
      dat_r_q <= '0;
    end else begin
      oe_l_q  <= oe_l_d;
      oe_r_q  <= oe_r_d;
      dat_l_q <= dat_l_d;
      dat_r_q <= dat_r_d;
    end
  end

  assign l_rd_oe = oe_l_q;
  assign r_rd_oe = oe_r_q;
  assign l_rdata = dat_l_q;
  assign r_rdata = dat_r_q;

endmodule

// File: rtl/dpbr_checker.sv
module dpbr_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mstr_sel,
  input logic          l_ce_n,
  input logic          l_rw_n,
  input logic          l_oe_n,
  input logic          l_sem_n,
  input logic [AW-1:0] l_addr,
  input logic          l_rd_oe,
  input logic          l_busy_n,
  input logic          r_ce_n,
  input logic          r_rw_n,
  input logic          r_oe_n,
  input logic          r_sem_n,
  input logic [AW-1:0] r_addr,
  input logic          r_rd_oe,
  input logic          r_busy_n
);

  logic rd_l, rd_r, same_acc;
  assign rd_l     = !l_ce_n && l_rw_n && !l_oe_n && l_sem_n;
  assign rd_r     = !r_ce_n && r_rw_n && !r_oe_n && r_sem_n;
  assign same_acc = !l_ce_n && l_sem_n && !r_ce_n && r_sem_n && (l_addr == r_addr);

  AST_READ_RAISES_OE_L: assert property (@(posedge clk) disable iff (!rst_n)
    rd_l |=> l_rd_oe); // R2
  AST_NOREAD_DROPS_OE_R: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_r |=> !r_rd_oe); // R3
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R6
  AST_BUSY_NEEDS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n || !r_busy_n) |-> (mstr_sel && same_acc)); // R5
  AST_SLAVE_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mstr_sel |-> (l_busy_n && r_busy_n)); // R10
  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mstr_sel && !r_busy_n) |=> (!r_busy_n || !$stable(l_addr) || !$stable(r_addr)
      || !$stable(l_ce_n) || !$stable(r_ce_n) || !$stable(l_sem_n)
      || !$stable(r_sem_n) || !$stable(mstr_sel))); // R8

endmodule

bind dual_port_busy_ram dpbr_checker #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .mstr_sel(mstr_sel),
  .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
  .l_addr(l_addr), .l_rd_oe(l_rd_oe), .l_busy_n(l_busy_n),
  .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
  .r_addr(r_addr), .r_rd_oe(r_rd_oe), .r_busy_n(r_busy_n)
);

// File: tb/dual_port_busy_ram_bench.sv
module dual_port_busy_ram_bench;

  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mstr_sel = 1'b1;
  logic l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1, l_sem_n = 1'b1, l_busy_in_n = 1'b1;
  logic r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1, r_sem_n = 1'b1, r_busy_in_n = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rd_oe, r_rd_oe, l_busy_n, r_busy_n;

  always #10 clk = ~clk;

  dual_port_busy_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dual_port_busy_ram (
    .clk(clk), .rst_n(rst_n), .mstr_sel(mstr_sel),
    .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_sem_n(l_sem_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rd_oe(l_rd_oe),
    .l_busy_n(l_busy_n), .l_busy_in_n(l_busy_in_n),
    .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_sem_n(r_sem_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rd_oe(r_rd_oe),
    .r_busy_n(r_busy_n), .r_busy_in_n(r_busy_in_n)
  );

  typedef struct {
    int          due;
    bit          port;
    bit          exp_oe;
    logic [7:0]  exp_d;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares registered read results against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.port == 1'b0) begin
          chk({it.req, " l_rd_oe"}, {31'd0, l_rd_oe}, {31'd0, it.exp_oe});
          if (it.exp_oe) chk({it.req, " l_rdata"}, {24'd0, l_rdata}, {24'd0, it.exp_d});
        end else begin
          chk({it.req, " r_rd_oe"}, {31'd0, r_rd_oe}, {31'd0, it.exp_oe});
          if (it.exp_oe) chk({it.req, " r_rdata"}, {24'd0, r_rdata}, {24'd0, it.exp_d});
        end
      end
    end
  end

  task automatic drv(input bit p, input bit ce_n, input bit rw_n, input bit oe_n,
                     input bit sem_n, input logic [AW-1:0] a, input logic [7:0] d);
    if (p == 1'b0) begin
      l_ce_n = ce_n; l_rw_n = rw_n; l_oe_n = oe_n; l_sem_n = sem_n; l_addr = a; l_wdata = d;
    end else begin
      r_ce_n = ce_n; r_rw_n = rw_n; r_oe_n = oe_n; r_sem_n = sem_n; r_addr = a; r_wdata = d;
    end
  endtask

  task automatic idle(input bit p);
    drv(p, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  task automatic expect_rd(input bit p, input bit oe, input logic [7:0] d, input string req);
    item_t it;
    it.due = cyc + 1; it.port = p; it.exp_oe = oe; it.exp_d = d; it.req = req;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busy_chk(input string req, input bit exp_l, input bit exp_r);
    #5;
    chk({req, " l_busy_n"}, {31'd0, l_busy_n}, {31'd0, exp_l});
    chk({req, " r_busy_n"}, {31'd0, r_busy_n}, {31'd0, exp_r});
  endtask

  task automatic rest();
    idle(0); idle(1); step(); step();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    // R4: state while reset is held
    chk("R4 rd_oe in reset", {30'd0, l_rd_oe, r_rd_oe}, 32'd0);
    busy_chk("R4 busy in reset", 1'b1, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    chk("R4 rd_oe after reset", {30'd0, l_rd_oe, r_rd_oe}, 32'd0);
    busy_chk("R4 busy after reset", 1'b1, 1'b1);

    // R1: writes from both ports, R2: reads from the opposite ports
    drv(0, 0, 0, 1, 1, 10'd3, 8'h5A); step();
    drv(0, 0, 0, 1, 1, 10'd7, 8'hC3); drv(1, 0, 0, 1, 1, 10'd9, 8'h0F); step();
    drv(0, 0, 1, 0, 1, 10'd9, 8'h00); drv(1, 0, 1, 0, 1, 10'd3, 8'h00);
    busy_chk("R5 different addresses", 1'b1, 1'b1);
    expect_rd(0, 1, 8'h0F, "R1 R2 left reads right's word");
    expect_rd(1, 1, 8'h5A, "R1 R2 right reads left's word");
    step();
    rest();

    // R3: output enable high, deselect, semaphore select
    drv(0, 0, 1, 1, 1, 10'd7, 8'h00); expect_rd(0, 0, 8'h00, "R3 oe_n high"); step();
    drv(0, 1, 0, 1, 1, 10'd7, 8'hFF); expect_rd(0, 0, 8'h00, "R3 ce_n high"); step();
    drv(0, 0, 0, 1, 0, 10'd7, 8'hEE); expect_rd(0, 0, 8'h00, "R3 sem_n low"); step();
    drv(0, 0, 1, 0, 1, 10'd7, 8'h00); expect_rd(0, 1, 8'hC3, "R3 word unchanged"); step();
    rest();

    // R7 R11 R9: same-cycle arrival, left writes, right (loser) reads old data
    drv(0, 0, 0, 1, 1, 10'd3, 8'h66); drv(1, 0, 1, 0, 1, 10'd3, 8'h00);
    busy_chk("R7 tie goes left", 1'b1, 1'b0);
    expect_rd(1, 1, 8'h5A, "R11 R9 loser read returns old word");
    step();
    idle(1);
    drv(0, 0, 1, 0, 1, 10'd3, 8'h00); expect_rd(0, 1, 8'h66, "R1 left write landed"); step();
    rest();

    // R6 R8 R9: left arrives first, right joins and loses
    drv(0, 0, 0, 1, 1, 10'd12, 8'h21); step();
    drv(1, 0, 0, 1, 1, 10'd12, 8'h99);
    busy_chk("R6 earlier left wins", 1'b1, 1'b0);
    step();
    busy_chk("R8 busy held", 1'b1, 1'b0);
    step();
    idle(1);
    busy_chk("R8 busy released", 1'b1, 1'b1);
    step();
    idle(0);
    drv(1, 0, 1, 0, 1, 10'd12, 8'h00); expect_rd(1, 1, 8'h21, "R9 loser write suppressed"); step();
    rest();

    // R6 R9: right arrives first, left joins and loses
    drv(1, 0, 0, 1, 1, 10'd14, 8'h44); step();
    drv(0, 0, 0, 1, 1, 10'd14, 8'h55);
    busy_chk("R6 earlier right wins", 1'b0, 1'b1);
    step();
    idle(1);
    drv(0, 0, 1, 0, 1, 10'd14, 8'h00); expect_rd(0, 1, 8'h44, "R9 left write dropped"); step();
    rest();

    // R10 R12: slave mode
    mstr_sel = 1'b0;
    drv(0, 0, 0, 1, 1, 10'd20, 8'hAA); drv(1, 0, 0, 1, 1, 10'd20, 8'hBB);
    busy_chk("R10 slave busy high", 1'b1, 1'b1);
    step();
    idle(1);
    drv(0, 0, 1, 0, 1, 10'd20, 8'h00); expect_rd(0, 1, 8'hAA, "R12 left wins double write"); step();
    rest();
    drv(1, 0, 0, 1, 1, 10'd21, 8'h33); step(); idle(1);
    l_busy_in_n = 1'b0;
    drv(0, 0, 0, 1, 1, 10'd21, 8'h77); step();
    drv(0, 0, 1, 0, 1, 10'd21, 8'h00); expect_rd(0, 1, 8'h33, "R10 blocked write, read allowed"); step();
    l_busy_in_n = 1'b1;
    rest();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule